// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block sits between a simple host port and a four-bank synchronous DRAM. It turns one-word read and write requests into device commands. Each command is set by the levels of chip select, row strobe, column strobe and write enable, together with a bank number and a 12-bit address bus. After reset it waits out the power-up delay. It then precharges every bank, issues two refresh cycles and programs the mode register. Only after that does it accept host traffic.

Every access opens one row and issues one column command with auto-precharge set, so no row is left open. The next command to any bank waits until the closing precharge has run its course. The block keeps its own refresh clock, with one refresh due every refresh period divided by the number of rows. A refresh that falls due wins over new host work, but it never cuts into an access that has already started.

All spacings are counted in clock cycles. The defaults suit a 166 MHz clock with CAS latency 3.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While reset is held, chip select is high. After reset it stays low. Commands use the {row strobe, column strobe, write enable} levels: activate 011, read 101, write 100, precharge 010, refresh 001, mode set 000. No-op is 111 and is driven in every cycle that carries no other command.
- R2: The first command after reset is a precharge with address bit 10 high, exactly INIT_US*CLK_MHZ cycles after reset is released. Refresh follows T_RP cycles later, a second refresh T_RC after that, and the mode set T_RC after the second refresh.
- R3: The mode set drives bank 0. Its address carries burst length code 000 in bits 2:0 and sequential order in bit 3. Bits 6:4 hold CAS_LAT and every other bit is zero.
- R4: host_ready stays low until the power-up sequence is done. A request held during power-up is taken only afterwards, T_MRD cycles after the mode set.
- R5: An accepted request drives activate on the next cycle, with the bank on BA and the row on A. The column command follows exactly T_RCD cycles after the activate.
- R6: The column command is write when host_we was high and read otherwise. It carries the column on A[7:0] and a 1 on A[10], with A[11], A[9] and A[8] at zero, and uses the same bank as the activate.
- R7: host_ack is high for exactly the one cycle in which the column command is on the bus.
- R8: After a read, the next command is issued max(T_RC-T_RCD, T_RAS+T_RP-T_RCD) cycles after the column command. After a write the gap is the larger of that value and T_DAL.
- R9: Once power-up is done, a refresh falls due every REFRESH_MS*1000*CLK_MHZ/REFRESH_ROWS cycles. While idle, consecutive refreshes are exactly that far apart.
- R10: A due refresh goes out before any new activate. If it falls due during an access, it follows that access's closing gap. The next command after a refresh waits T_RC cycles.
- R11: host_ready is high only when the sequencer is idle, has no spacing still running and has no refresh due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Access request, taken on an edge where host_ready is high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 22 | {bank[1:0], row[11:0], column[7:0]} |
| host_ready | output | 1 | Sequencer can take a request this cycle |
| host_ack | output | 1 | Column command for the taken request is on the bus |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank number |
| sd_a | output | 12 | Row, column or mode word |

## Verification
The bench sets an 8 MHz clock figure and a 4 us power-up, so power-up takes 32 cycles. It divides the 64 ms period over 1280 rows, which gives a refresh every 400 cycles, so several refresh intervals fit in a short run. CAS latency 2 gives a mode word different from the default. T_DAL is raised to 9 so the write gap (9 cycles) differs from the read gap (7 cycles), and both must come out distinct at the bus. The refresh is then timed to fall due both while the sequencer is idle and in the middle of an access.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // Encoded as {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_BST = 3'b110,
    CMD_NOP = 3'b111
  } sdram_cmd_e;

  typedef enum logic [2:0] {
    ST_PRE_ALL,
    ST_REF_1,
    ST_REF_2,
    ST_MRS,
    ST_IDLE,
    ST_COL
  } seq_state_e;

  function automatic int imax(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

  function automatic int power_up_cycles(input int us, input int mhz);
    return us * mhz;
  endfunction

  function automatic int refresh_interval(input int ms, input int mhz, input int rows);
    return (ms * 1000 * mhz) / rows;
  endfunction

  // Cycles from a read column command (auto-precharge) to the next command
  function automatic int read_gap(input int rcd, input int ras, input int rp, input int rc);
    return imax(1, imax(rc - rcd, ras + rp - rcd));
  endfunction

  // Single-beat write: the data beat is the column cycle itself
  function automatic int write_gap(input int rcd, input int ras, input int rp, input int rc,
                                   input int dal);
    return imax(read_gap(rcd, ras, rp, rc), dal);
  endfunction

  // Burst length one (code 0), sequential order, latency in bits 6:4
  function automatic int mode_word(input int cl);
    return (cl & 7) << 4;
  endfunction

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
  parameter int W         = 16,
  parameter int RESET_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= W'(RESET_VAL);
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // A new spacing is only started once the previous one has run out (R8)
  p_load_when_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> zero);

endmodule

// File: rtl/sdram_refresh_tick.sv
module sdram_refresh_tick #(
  parameter int INTERVAL = 2593,
  localparam int W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic served,
  output logic pending
);

  logic [W-1:0] cnt_q;
  logic         expire;

  assign expire = enable && (cnt_q == W'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pending <= 1'b0;
    end else begin
      if (enable) cnt_q <= expire ? '0 : cnt_q + 1'b1;
      if (expire)      pending <= 1'b1;
      else if (served) pending <= 1'b0;
    end
  end

  // A refresh is only issued against a due request (R9)
  p_served_needs_due_r9: assert property (@(posedge clk) disable iff (!rst_n)
    served |-> pending);

  // No interval elapses while the previous one is still owed (R9)
  p_no_lost_refresh_r9: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (!pending || served));

endmodule

// File: rtl/sdram_cmd_drive.sv
module sdram_cmd_drive
  import sdram_seq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sdram_cmd_e        cmd_nxt,
  input  logic [BANK_W-1:0] ba_nxt,
  input  logic [ADDR_W-1:0] a_nxt,
  input  logic              ack_nxt,
  output sdram_cmd_e        cmd_q,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] ba,
  output logic [ADDR_W-1:0] a,
  output logic              ack
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_n  <= 1'b1;
      cmd_q <= CMD_NOP;
      ba    <= '0;
      a     <= '0;
      ack   <= 1'b0;
    end else begin
      cs_n  <= 1'b0;
      cmd_q <= cmd_nxt;
      ba    <= ba_nxt;
      a     <= a_nxt;
      ack   <= ack_nxt;
    end
  end

  assign {ras_n, cas_n, we_n} = 3'(cmd_q);

  // The acknowledge travels with the column command (R7)
  p_ack_is_column_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (cmd_q == CMD_RD || cmd_q == CMD_WR));
  p_column_has_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> ack);

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int BANK_W       = 2,
  parameter int ROW_W        = 12,
  parameter int COL_W        = 8,
  parameter int CLK_MHZ      = 166,
  parameter int INIT_US      = 200,
  parameter int REFRESH_MS   = 64,
  parameter int REFRESH_ROWS = 4096,
  parameter int CAS_LAT      = 3,
  parameter int T_RCD        = 3,
  parameter int T_RP         = 3,
  parameter int T_RAS        = 7,
  parameter int T_RC         = 10,
  parameter int T_MRD        = 2,
  parameter int T_DAL        = 5,
  localparam int HADDR_W     = BANK_W + ROW_W + COL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [HADDR_W-1:0] host_addr,
  output logic               host_ready,
  output logic               host_ack,
  output logic               sd_cs_n,
  output logic               sd_ras_n,
  output logic               sd_cas_n,
  output logic               sd_we_n,
  output logic [BANK_W-1:0]  sd_ba,
  output logic [ROW_W-1:0]   sd_a
);

  localparam int AP_BIT   = 10;
  localparam int INIT_CYC = power_up_cycles(INIT_US, CLK_MHZ);
  localparam int REFI     = refresh_interval(REFRESH_MS, CLK_MHZ, REFRESH_ROWS);
  localparam int RD_GAP   = read_gap(T_RCD, T_RAS, T_RP, T_RC);
  localparam int WR_GAP   = write_gap(T_RCD, T_RAS, T_RP, T_RC, T_DAL);
  localparam int GAP_MAX  = imax(imax(INIT_CYC, WR_GAP), imax(T_RC, imax(T_RP, T_MRD)));
  localparam int GAP_W    = $clog2(GAP_MAX + 1);
  localparam int TRK_W    = 8;
  localparam logic [TRK_W-1:0] TRK_SAT = '1;

  // ---------------- state ----------------
  seq_state_e          state_q, state_d;
  logic                init_done_q;
  logic [BANK_W-1:0]   bank_q;
  logic [COL_W-1:0]    col_q;
  logic                we_q;

  // named internal events
  logic                gap_zero;
  logic                gap_load;
  logic [GAP_W-1:0]    gap_val;
  logic                ref_pend;
  logic                ref_served;
  logic                accept;
  sdram_cmd_e          cmd_nxt;
  sdram_cmd_e          cmd_q;
  logic [BANK_W-1:0]   ba_nxt;
  logic [ROW_W-1:0]    a_nxt;
  logic                ack_nxt;

  logic [BANK_W-1:0]   req_bank;
  logic [ROW_W-1:0]    req_row;
  logic [COL_W-1:0]    req_col;

  assign req_bank = host_addr[HADDR_W-1 -: BANK_W];
  assign req_row  = host_addr[COL_W +: ROW_W];
  assign req_col  = host_addr[COL_W-1:0];

  sdram_gap_timer #(.W(GAP_W), .RESET_VAL(INIT_CYC - 1)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (gap_load),
    .load_val (gap_val),
    .zero     (gap_zero)
  );

  sdram_refresh_tick #(.INTERVAL(REFI)) u_refresh (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (init_done_q),
    .served  (ref_served),
    .pending (ref_pend)
  );

  // ---------------- sequencing ----------------
  always_comb begin
    state_d    = state_q;
    cmd_nxt    = CMD_NOP;
    ba_nxt     = '0;
    a_nxt      = '0;
    ack_nxt    = 1'b0;
    gap_load   = 1'b0;
    gap_val    = '0;
    ref_served = 1'b0;
    accept     = 1'b0;
    if (gap_zero) begin
      unique case (state_q)
        ST_PRE_ALL: begin
          cmd_nxt       = CMD_PRE;
          a_nxt[AP_BIT] = 1'b1;
          gap_load      = 1'b1;
          gap_val       = GAP_W'(T_RP - 1);
          state_d       = ST_REF_1;
        end
        ST_REF_1, ST_REF_2: begin
          cmd_nxt  = CMD_REF;
          gap_load = 1'b1;
          gap_val  = GAP_W'(T_RC - 1);
          state_d  = (state_q == ST_REF_1) ? ST_REF_2 : ST_MRS;
        end
        ST_MRS: begin
          cmd_nxt  = CMD_MRS;
          a_nxt    = ROW_W'(mode_word(CAS_LAT));
          gap_load = 1'b1;
          gap_val  = GAP_W'(T_MRD - 1);
          state_d  = ST_IDLE;
        end
        ST_IDLE: begin
          if (ref_pend) begin
            cmd_nxt    = CMD_REF;
            ref_served = 1'b1;
            gap_load   = 1'b1;
            gap_val    = GAP_W'(T_RC - 1);
          end else if (host_req) begin
            cmd_nxt  = CMD_ACT;
            ba_nxt   = req_bank;
            a_nxt    = req_row;
            accept   = 1'b1;
            gap_load = 1'b1;
            gap_val  = GAP_W'(T_RCD - 1);
            state_d  = ST_COL;
          end
        end
        ST_COL: begin
          cmd_nxt              = we_q ? CMD_WR : CMD_RD;
          ba_nxt               = bank_q;
          a_nxt[COL_W-1:0]     = col_q;
          a_nxt[AP_BIT]        = 1'b1;
          ack_nxt              = 1'b1;
          gap_load             = 1'b1;
          gap_val              = we_q ? GAP_W'(WR_GAP - 1) : GAP_W'(RD_GAP - 1);
          state_d              = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_PRE_ALL;
      init_done_q <= 1'b0;
      bank_q      <= '0;
      col_q       <= '0;
      we_q        <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_MRS && gap_zero) init_done_q <= 1'b1;
      if (accept) begin
        bank_q <= req_bank;
        col_q  <= req_col;
        we_q   <= host_we;
      end
    end
  end

  assign host_ready = (state_q == ST_IDLE) && gap_zero && !ref_pend;

  sdram_cmd_drive #(.BANK_W(BANK_W), .ADDR_W(ROW_W)) u_drive (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_nxt (cmd_nxt),
    .ba_nxt  (ba_nxt),
    .a_nxt   (a_nxt),
    .ack_nxt (ack_nxt),
    .cmd_q   (cmd_q),
    .cs_n    (sd_cs_n),
    .ras_n   (sd_ras_n),
    .cas_n   (sd_cas_n),
    .we_n    (sd_we_n),
    .ba      (sd_ba),
    .a       (sd_a),
    .ack     (host_ack)
  );

  // ---------------- bus spacing trackers for the assertions ----------------
  logic [TRK_W-1:0] since_act, since_ref, since_mrs, since_col;
  logic             last_col_wr;
  logic             col_on_bus;

  assign col_on_bus = (cmd_q == CMD_RD) || (cmd_q == CMD_WR);

  function automatic logic [TRK_W-1:0] bump(input logic [TRK_W-1:0] v);
    return (v == TRK_SAT) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act   <= TRK_SAT;
      since_ref   <= TRK_SAT;
      since_mrs   <= TRK_SAT;
      since_col   <= TRK_SAT;
      last_col_wr <= 1'b0;
    end else begin
      since_act <= (cmd_q == CMD_ACT) ? TRK_W'(1) : bump(since_act);
      since_ref <= (cmd_q == CMD_REF) ? TRK_W'(1) : bump(since_ref);
      since_mrs <= (cmd_q == CMD_MRS) ? TRK_W'(1) : bump(since_mrs);
      since_col <= col_on_bus         ? TRK_W'(1) : bump(since_col);
      if (col_on_bus) last_col_wr <= (cmd_q == CMD_WR);
    end
  end

  p_rcd_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
    col_on_bus |-> (since_act == TRK_W'(T_RCD)));

  p_autoprecharge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    col_on_bus |-> sd_a[AP_BIT]);

  p_row_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_ACT) |-> (since_act >= TRK_W'(T_RC)));

  p_write_recovery_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_ACT && last_col_wr) |-> (since_col >= TRK_W'(T_DAL)));

  p_refresh_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_ACT || cmd_q == CMD_REF) |-> (since_ref >= TRK_W'(T_RC)));

  p_refresh_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_ACT) |-> !$past(ref_pend));

  p_mode_settle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != CMD_NOP) |-> (since_mrs >= TRK_W'(T_MRD)));

  p_ready_after_init_r4: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> init_done_q);

  p_chip_selected_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> !sd_cs_n);

endmodule

// File: tb/sdram_cmd_seq_tb.sv
module sdram_cmd_seq_tb;

  localparam int P_MHZ   = 8;
  localparam int P_US    = 4;
  localparam int P_MS    = 64;
  localparam int P_ROWS  = 1280;
  localparam int P_CL    = 2;
  localparam int P_DAL   = 9;
  localparam int P_RCD   = 3;
  localparam int P_RP    = 3;
  localparam int P_RAS   = 7;
  localparam int P_RC    = 10;
  localparam int P_MRD   = 2;

  // Expectations restated from the requirements
  localparam int E_INIT  = P_US * P_MHZ;                     // 32
  localparam int E_REFI  = P_MS * 1000 * P_MHZ / P_ROWS;     // 400
  localparam int E_MODE  = P_CL * 16;                        // 0x020
  localparam int E_RDG   = ((P_RC - P_RCD) > (P_RAS + P_RP - P_RCD)) ?
                           (P_RC - P_RCD) : (P_RAS + P_RP - P_RCD);   // 7
  localparam int E_WRG   = (P_DAL > E_RDG) ? P_DAL : E_RDG;           // 9

  localparam logic [2:0] B_NOP = 3'b111, B_ACT = 3'b011, B_RD = 3'b101,
                         B_WR  = 3'b100, B_PRE = 3'b010, B_REF = 3'b001,
                         B_MRS = 3'b000;

  // {we, bank, row, col}
  localparam logic [22:0] VEC [0:5] = '{
    {1'b0, 2'd0, 12'h000, 8'h00},
    {1'b1, 2'd3, 12'hFFF, 8'hFF},
    {1'b0, 2'd1, 12'h5A5, 8'h3C},
    {1'b1, 2'd2, 12'h0F0, 8'h81},
    {1'b1, 2'd1, 12'h123, 8'h7E},
    {1'b0, 2'd3, 12'hABC, 8'h01}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_req;
  logic        host_we;
  logic [21:0] host_addr;
  logic        host_ready, host_ack;
  logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_ba;
  logic [11:0] sd_a;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_cmd_seq #(
    .CLK_MHZ(P_MHZ), .INIT_US(P_US), .REFRESH_MS(P_MS), .REFRESH_ROWS(P_ROWS),
    .CAS_LAT(P_CL), .T_DAL(P_DAL)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_ready(host_ready), .host_ack(host_ack),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_a(sd_a)
  );

  function automatic logic [2:0] bus_cmd();
    return {sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  task automatic check(input string tag, input int actual, input int expected);
    n_chk++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, actual, expected);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Next non-NOP command on the bus, sampled at falling edges
  task automatic next_cmd(output logic [2:0] c, output int at);
    bit found = 1'b0;
    c  = B_NOP;
    at = -1;
    for (int k = 0; k < 2000 && !found; k++) begin
      @(negedge clk);
      if (bus_cmd() != B_NOP) begin
        c     = bus_cmd();
        at    = cyc;
        found = 1'b1;
      end
    end
  endtask

  // Checks the column command that follows an activate at act_at
  task automatic check_column(input logic [22:0] v, input int act_at, output int col_at);
    logic [2:0] c;
    next_cmd(c, col_at);
    check("R6 column kind", c, v[22] ? B_WR : B_RD);
    check("R5 column spacing", col_at - act_at, P_RCD);
    check("R6 column address", sd_a, 12'h400 | v[7:0]);
    check("R6 column bank", sd_ba, v[21:20]);
    check("R7 ack with column", host_ack, 1);
    @(negedge clk);
    check("R7 ack single cycle", host_ack, 0);
  endtask

  task automatic do_access(input logic [22:0] v, input bit time_gap);
    int t0, col_at;
    while (!host_ready) @(negedge clk);
    host_req  = 1'b1;
    host_we   = v[22];
    host_addr = v[21:0];
    t0 = cyc;
    @(negedge clk);
    host_req = 1'b0;
    check("R5 activate issued", bus_cmd(), B_ACT);
    check("R5 activate next cycle", cyc - t0, 1);
    check("R5 activate bank", sd_ba, v[21:20]);
    check("R5 activate row", sd_a, v[19:8]);
    check_column(v, cyc, col_at);
    if (time_gap) begin
      while (!host_ready) @(negedge clk);
      check("R8 recovery gap", cyc - col_at + 1, v[22] ? E_WRG : E_RDG);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected 0 cycles left", 0);
    finish_run();
  end

  initial begin
    logic [2:0] c;
    int rel, pre_at, r1_at, r2_at, mrs_at, act_at, col_at, rf1, rf2, rf3;
    logic [22:0] v0;

    rst_n     = 1'b0;
    v0        = {1'b0, 2'd2, 12'h3C3, 8'h5A};
    host_req  = 1'b1;           // held through power-up (R4)
    host_we   = v0[22];
    host_addr = v0[21:0];
    repeat (3) @(negedge clk);
    check("R1 reset deselect", sd_cs_n, 1);
    check("R1 reset strobes idle", bus_cmd(), B_NOP);
    check("R4 reset not ready", host_ready, 0);
    check("R7 reset no ack", host_ack, 0);
    rst_n = 1'b1;
    rel   = cyc;

    // ---- power-up sequence ----
    next_cmd(c, pre_at);
    check("R2 first is precharge", c, B_PRE);
    check("R2 power-up wait", pre_at - rel, E_INIT);
    check("R2 precharge all flag", sd_a[10], 1);
    check("R1 chip selected", sd_cs_n, 0);
    check("R4 held during power-up", host_ready, 0);
    next_cmd(c, r1_at);
    check("R2 refresh one", c, B_REF);
    check("R2 precharge spacing", r1_at - pre_at, P_RP);
    next_cmd(c, r2_at);
    check("R2 refresh two", c, B_REF);
    check("R2 refresh spacing", r2_at - r1_at, P_RC);
    next_cmd(c, mrs_at);
    check("R2 mode set", c, B_MRS);
    check("R2 mode set spacing", mrs_at - r2_at, P_RC);
    check("R3 mode word", sd_a, E_MODE);
    check("R3 mode bank", sd_ba, 0);
    check("R4 not ready at mode set", host_ready, 0);
    @(negedge clk);
    check("R11 ready after mode settle", host_ready, 1);
    @(negedge clk);
    host_req = 1'b0;
    check("R4 held request activates", bus_cmd(), B_ACT);
    check("R4 activate after mode set", cyc - mrs_at, P_MRD);
    check("R5 held request row", sd_a, v0[19:8]);
    check_column(v0, cyc, col_at);

    // ---- table of accesses ----
    for (int i = 0; i < 6; i++) do_access(VEC[i], 1'b1);

    // ---- refresh cadence while idle (R9) ----
    next_cmd(c, rf1);
    check("R9 refresh due", c, B_REF);
    next_cmd(c, rf2);
    check("R9 second refresh", c, B_REF);
    check("R9 refresh interval", rf2 - rf1, E_REFI);

    // ---- refresh wins over a new request (R10) ----
    while (cyc < rf2 + E_REFI - 1) @(negedge clk);
    check("R11 not ready when refresh due", host_ready, 0);
    v0        = {1'b1, 2'd1, 12'h777, 8'h44};
    host_req  = 1'b1;
    host_we   = v0[22];
    host_addr = v0[21:0];
    next_cmd(c, rf3);
    check("R10 refresh before activate", c, B_REF);
    check("R9 refresh on time", rf3 - rf2, E_REFI);
    while (!host_ready) @(negedge clk);
    check("R10 ready after refresh gap", cyc - rf3 + 1, P_RC);
    @(negedge clk);
    host_req = 1'b0;
    act_at   = cyc;
    check("R10 activate after refresh", bus_cmd(), B_ACT);
    check_column(v0, act_at, col_at);

    // ---- refresh falling due mid-access waits for its gap (R10) ----
    while (cyc < rf3 + E_REFI - 4) @(negedge clk);
    check("R11 ready before refresh due", host_ready, 1);
    v0        = {1'b0, 2'd0, 12'h222, 8'h10};
    host_req  = 1'b1;
    host_we   = v0[22];
    host_addr = v0[21:0];
    @(negedge clk);
    host_req = 1'b0;
    act_at   = cyc;
    check("R5 activate ahead of refresh", bus_cmd(), B_ACT);
    check_column(v0, act_at, col_at);
    next_cmd(c, rf1);
    check("R10 deferred refresh", c, B_REF);
    check("R10 refresh after read gap", rf1 - col_at, E_RDG);

    finish_run();
  end

endmodule